// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This block sits between one pad and the core logic that uses it. Static configuration bits choose how the cell behaves. It can pass the pad straight into the core, capture the pad in a flip-flop, or hold it in a transparent latch. It can also drive the pad from the core, or do both with tri-state control. The capture element takes its clock from one of several I/O clock lines, chosen by a static select. An active-low reset clears the capture state.

The pad driver enable has several possible sources: always on, a product-term enable from the driving logic, or that enable qualified by a chip-wide output-enable pin. The chip-wide pin can instead act as an ordinary data input. In that case its value is forwarded to the core and it no longer gates any driver. A slow-slew configuration bit is exported unchanged as a flag for the pad driver. The data width is a parameter, so one instance can serve a group of pads that share one configuration.

Top module: `iocell_top`

## Requirements
- R1: `cfg_mode` encodes 000 combinational input, 001 registered input, 010 latched input, 011 output, 100 bidirectional. In 000, 001, 010 and in the unused codes 101 to 111, `pad_oe` is 0.
- R2: In modes 000, 100 and 101 to 111, `core_din` follows `pad_i` combinationally.
- R3: In mode 001, `core_din` takes the value `pad_i` had at the rising edge of the selected I/O clock, and holds it between edges.
- R4: In mode 010, `core_din` follows `pad_i` while the selected I/O clock is high, and holds its value while that clock is low.
- R5: `cfg_clk_sel` = k selects `io_clk[k]` for the capture element. Edges on the other clock lines have no effect.
- R6: While `rst_n` is 0, the flip-flop and the latch are both cleared asynchronously, so `core_din` is 0 in modes 001 and 010.
- R7: In modes 011 and 100, `cfg_oe_src` sets `pad_oe`: 00 gives 1, 01 gives `pt_oe`, 10 gives `gpin & pt_oe`, 11 gives 0.
- R8: When `cfg_gpin_is_data` is 1, `gpin_data` equals `gpin` and the pin is treated as 1 by OE source 10. When it is 0, `gpin_data` is 0.
- R9: `pad_o` equals `core_dout` when `pad_oe` is 1, and is 0 otherwise.
- R10: In mode 011, `core_din` is 0.
- R11: `slow_slew` equals `cfg_slow_slew` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | NUM_IOCLK | I/O clock lines |
| rst_n | input | 1 | Active-low asynchronous clear of the capture state |
| cfg_mode | input | 3 | Cell mode code |
| cfg_oe_src | input | 2 | Driver enable source select |
| cfg_clk_sel | input | SELW | Index of the I/O clock used for capture |
| cfg_slow_slew | input | 1 | Slew setting to pass to the pad |
| cfg_gpin_is_data | input | 1 | Use the chip-wide enable pin as a data input |
| core_dout | input | WIDTH | Data from core to pad |
| pt_oe | input | 1 | Product-term output enable |
| gpin | input | 1 | Chip-wide output-enable / dedicated input pin |
| pad_i | input | WIDTH | Value seen on the pad |
| pad_o | output | WIDTH | Value to drive on the pad |
| pad_oe | output | 1 | Pad driver enable |
| core_din | output | WIDTH | Input path value to core |
| gpin_data | output | 1 | Chip-wide pin forwarded as data |
| slow_slew | output | 1 | Slew flag for the pad driver |

## Verification
The properties sample everything on the rising edge of `io_clk[0]`. They assume that configuration, pad and core inputs are settled at that edge and change only between edges. They also assume that reset spans at least one such edge. The stimulus changes every input 1 ns after a rising edge of `io_clk[0]` and samples 2 ns later. The second clock line is phased so that its edges never meet an edge of the first, and checks that involve it wait on its own edges.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

   typedef enum logic [2:0] {
      IOM_COMB  = 3'b000,
      IOM_REG   = 3'b001,
      IOM_LATCH = 3'b010,
      IOM_OUT   = 3'b011,
      IOM_BIDIR = 3'b100
   } iom_e;

   typedef enum logic [1:0] {
      OES_ON     = 2'b00,
      OES_PT     = 2'b01,
      OES_GLB_PT = 2'b10,
      OES_OFF    = 2'b11
   } oes_e;

   function automatic int sel_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/iocell_clk_mux.sv
module iocell_clk_mux #(
   parameter int NUM_IOCLK = 2,
   parameter int SELW      = 1
) (
   input  logic [NUM_IOCLK-1:0] clk_in,
   input  logic [SELW-1:0]      sel,
   output logic                 clk_out
);
   generate
      if (NUM_IOCLK == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel;
         assign clk_out    = clk_in[0];
      end else begin : g_multi
         assign clk_out = clk_in[sel];
      end
   endgenerate
endmodule

// File: rtl/iocell_capture.sv
module iocell_capture #(
   parameter int WIDTH    = 1,
   parameter bit LATCH_EN = 1'b1
) (
   input  logic             cap_clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q_reg,
   output logic [WIDTH-1:0] q_lat
);
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         always_ff @(posedge cap_clk or negedge rst_n) begin
            if (!rst_n) q_reg[b] <= 1'b0;
            else        q_reg[b] <= d[b];
         end

         if (LATCH_EN) begin : g_latch
            always_latch begin
               if (!rst_n)       q_lat[b] = 1'b0;
               else if (cap_clk) q_lat[b] = d[b];
            end
         end else begin : g_nolatch
            assign q_lat[b] = d[b];
         end
      end
   endgenerate
endmodule

// File: rtl/iocell_oe_ctrl.sv
module iocell_oe_ctrl
   import iocell_pkg::*;
(
   input  logic [2:0] mode,
   input  logic [1:0] oe_src,
   input  logic       pt_oe,
   input  logic       gpin,
   input  logic       gpin_is_data,
   output logic       drive
);
   logic glb_en;
   logic src_en;
   logic drv_mode;

   always_comb begin
      glb_en = gpin_is_data ? 1'b1 : gpin;
      unique case (oe_src)
         OES_ON:     src_en = 1'b1;
         OES_PT:     src_en = pt_oe;
         OES_GLB_PT: src_en = glb_en & pt_oe;
         default:    src_en = 1'b0;
      endcase
      drv_mode = (mode == IOM_OUT) || (mode == IOM_BIDIR);
      drive    = drv_mode & src_en;
   end
endmodule

// File: rtl/iocell_top.sv
module iocell_top
   import iocell_pkg::*;
#(
   parameter int WIDTH     = 1,
   parameter int NUM_IOCLK = 2,
   parameter bit LATCH_EN  = 1'b1,
   localparam int SELW     = sel_w(NUM_IOCLK)
) (
   input  logic [NUM_IOCLK-1:0] io_clk,
   input  logic                 rst_n,
   input  logic [2:0]           cfg_mode,
   input  logic [1:0]           cfg_oe_src,
   input  logic [SELW-1:0]      cfg_clk_sel,
   input  logic                 cfg_slow_slew,
   input  logic                 cfg_gpin_is_data,
   input  logic [WIDTH-1:0]     core_dout,
   input  logic                 pt_oe,
   input  logic                 gpin,
   input  logic [WIDTH-1:0]     pad_i,
   output logic [WIDTH-1:0]     pad_o,
   output logic                 pad_oe,
   output logic [WIDTH-1:0]     core_din,
   output logic                 gpin_data,
   output logic                 slow_slew
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("iocell_top: WIDTH must be at least 1");
      end
      if (!(NUM_IOCLK == 1 || NUM_IOCLK == 2 || NUM_IOCLK == 4)) begin : g_bad_clk
         $error("iocell_top: NUM_IOCLK must be 1, 2 or 4");
      end
   endgenerate

   logic             cap_clk;
   logic [WIDTH-1:0] q_reg;
   logic [WIDTH-1:0] q_lat;
   logic             drive;

   iocell_clk_mux #(.NUM_IOCLK(NUM_IOCLK), .SELW(SELW)) u_clk_mux (
      .clk_in  (io_clk),
      .sel     (cfg_clk_sel),
      .clk_out (cap_clk)
   );

   iocell_capture #(.WIDTH(WIDTH), .LATCH_EN(LATCH_EN)) u_capture (
      .cap_clk (cap_clk),
      .rst_n   (rst_n),
      .d       (pad_i),
      .q_reg   (q_reg),
      .q_lat   (q_lat)
   );

   iocell_oe_ctrl u_oe_ctrl (
      .mode         (cfg_mode),
      .oe_src       (cfg_oe_src),
      .pt_oe        (pt_oe),
      .gpin         (gpin),
      .gpin_is_data (cfg_gpin_is_data),
      .drive        (drive)
   );

   always_comb begin
      unique case (cfg_mode)
         IOM_REG:   core_din = q_reg;
         IOM_LATCH: core_din = q_lat;
         IOM_OUT:   core_din = '0;
         default:   core_din = pad_i;
      endcase
   end

   assign pad_oe    = drive;
   assign pad_o     = {WIDTH{drive}} & core_dout;
   assign gpin_data = cfg_gpin_is_data & gpin;
   assign slow_slew = cfg_slow_slew;
endmodule

// File: rtl/iocell_chk.sv
module iocell_chk
   import iocell_pkg::*;
#(
   parameter int WIDTH     = 1,
   parameter int NUM_IOCLK = 2,
   parameter int SELW      = 1
) (
   input logic [NUM_IOCLK-1:0] io_clk,
   input logic                 rst_n,
   input logic [2:0]           cfg_mode,
   input logic [1:0]           cfg_oe_src,
   input logic [SELW-1:0]      cfg_clk_sel,
   input logic                 cfg_gpin_is_data,
   input logic                 pt_oe,
   input logic [WIDTH-1:0]     pad_i,
   input logic                 pad_oe,
   input logic [WIDTH-1:0]     core_din,
   input logic                 gpin_data
);
   logic drv_mode;
   assign drv_mode = (cfg_mode == IOM_OUT) || (cfg_mode == IOM_BIDIR);

   p_input_hiz_r1: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      !drv_mode |-> !pad_oe);

   p_comb_pass_r2: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      (cfg_mode == IOM_COMB) |-> (core_din == pad_i));

   p_reg_capture_r3: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      ((cfg_mode == IOM_REG) && (cfg_clk_sel == '0)) ##1
      ((cfg_mode == IOM_REG) && (cfg_clk_sel == '0))
      |-> (core_din == $past(pad_i)));

   p_oe_off_r7: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      (drv_mode && (cfg_oe_src == OES_OFF)) |-> !pad_oe);

   p_oe_pt_r7: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      (drv_mode && (cfg_oe_src == OES_PT)) |-> (pad_oe == pt_oe));

   p_gpin_data_r8: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      !cfg_gpin_is_data |-> !gpin_data);

   p_out_din_zero_r10: assert property (@(posedge io_clk[0]) disable iff (!rst_n)
      (cfg_mode == IOM_OUT) |-> (core_din == '0));
endmodule

bind iocell_top iocell_chk #(.WIDTH(WIDTH), .NUM_IOCLK(NUM_IOCLK), .SELW(SELW)) u_chk (
   .io_clk           (io_clk),
   .rst_n            (rst_n),
   .cfg_mode         (cfg_mode),
   .cfg_oe_src       (cfg_oe_src),
   .cfg_clk_sel      (cfg_clk_sel),
   .cfg_gpin_is_data (cfg_gpin_is_data),
   .pt_oe            (pt_oe),
   .pad_i            (pad_i),
   .pad_oe           (pad_oe),
   .core_din         (core_din),
   .gpin_data        (gpin_data)
);

// File: tb/tb_iocell_top.sv
`timescale 1ns/1ps
module tb_iocell_top;
   logic       clk0;
   logic       clk1;
   logic       rst_n;
   logic [2:0] cfg_mode;
   logic [1:0] cfg_oe_src;
   logic [0:0] cfg_clk_sel;
   logic       cfg_slow_slew;
   logic       cfg_gpin_is_data;
   logic [0:0] core_dout;
   logic       pt_oe;
   logic       gpin;
   logic [0:0] pad_i;
   logic [0:0] pad_o;
   logic       pad_oe;
   logic [0:0] core_din;
   logic       gpin_data;
   logic       slow_slew;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   iocell_top dut (
      .io_clk           ({clk1, clk0}),
      .rst_n            (rst_n),
      .cfg_mode         (cfg_mode),
      .cfg_oe_src       (cfg_oe_src),
      .cfg_clk_sel      (cfg_clk_sel),
      .cfg_slow_slew    (cfg_slow_slew),
      .cfg_gpin_is_data (cfg_gpin_is_data),
      .core_dout        (core_dout),
      .pt_oe            (pt_oe),
      .gpin             (gpin),
      .pad_i            (pad_i),
      .pad_o            (pad_o),
      .pad_oe           (pad_oe),
      .core_din         (core_din),
      .gpin_data        (gpin_data),
      .slow_slew        (slow_slew)
   );

   // 125 MHz main clock, rising at 4 mod 8 ns
   initial begin
      clk0 = 1'b0;
      forever #4 clk0 = ~clk0;
   end

   // second I/O clock, edges at 2 mod 12 ns, never on a clk0 edge
   initial begin
      clk1 = 1'b0;
      #2;
      forever begin
         clk1 = ~clk1;
         #12;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // fields: mode[13:11] oesrc[10:9] gdata[8] pt[7] gpin[6] dout[5] pad[4]
   //         exp_oe[3] exp_o[2] exp_din[1] exp_gdata[0]
   localparam int NVEC = 14;
   localparam logic [13:0] VEC [0:NVEC-1] = '{
      14'b000_00_0_1_1_1_1_0_0_1_0,
      14'b000_00_0_1_1_1_0_0_0_0_0,
      14'b011_00_0_0_0_1_1_1_1_0_0,
      14'b011_01_0_0_1_1_0_0_0_0_0,
      14'b011_01_0_1_0_1_0_1_1_0_0,
      14'b011_10_0_1_0_1_0_0_0_0_0,
      14'b011_10_0_1_1_1_0_1_1_0_0,
      14'b011_10_1_1_0_1_0_1_1_0_0,
      14'b011_10_1_0_1_1_0_0_0_0_1,
      14'b011_11_0_1_1_1_1_0_0_0_0,
      14'b100_00_0_1_1_0_1_1_0_1_0,
      14'b100_01_0_0_1_1_1_0_0_1_0,
      14'b101_00_0_1_1_1_1_0_0_1_0,
      14'b111_00_1_1_1_1_0_0_0_0_1
   };

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

   initial begin
      rst_n            = 1'b0;
      cfg_mode         = 3'b001;
      cfg_oe_src       = 2'b00;
      cfg_clk_sel      = 1'b0;
      cfg_slow_slew    = 1'b0;
      cfg_gpin_is_data = 1'b0;
      core_dout        = 1'b1;
      pt_oe            = 1'b1;
      gpin             = 1'b1;
      pad_i            = 1'b1;
      #6;
      chk("R6 reset clears registered input", core_din, 0);
      chk("R1 reset state driver off", pad_oe, 0);
      chk("R9 reset state pad_o parked", pad_o, 0);
      @(negedge clk0);
      #1 rst_n = 1'b1;

      // table walk: combinational behaviour
      for (int i = 0; i < NVEC; i++) begin
         @(posedge clk0);
         #1;
         cfg_mode         = VEC[i][13:11];
         cfg_oe_src       = VEC[i][10:9];
         cfg_gpin_is_data = VEC[i][8];
         pt_oe            = VEC[i][7];
         gpin             = VEC[i][6];
         core_dout        = VEC[i][5];
         pad_i            = VEC[i][4];
         cfg_slow_slew    = i[0];
         #2;
         chk("R1 R7 pad_oe", pad_oe, VEC[i][3]);
         chk("R9 pad_o", pad_o, VEC[i][2]);
         chk("R2 R10 core_din", core_din, VEC[i][1]);
         chk("R8 gpin_data", gpin_data, VEC[i][0]);
         chk("R11 slow_slew", slow_slew, i[0]);
      end

      // R3: registered input on io_clk[0]
      @(posedge clk0);
      #1 cfg_mode = 3'b001; cfg_clk_sel = 1'b0; pad_i = 1'b0;
      @(posedge clk0);
      #1 pad_i = 1'b1;
      #1 chk("R3 holds between edges", core_din, 0);
      @(posedge clk0);
      #1 chk("R3 captured at edge", core_din, 1);
      pad_i = 1'b0;
      #1 chk("R3 pad change between edges ignored", core_din, 1);

      // R5: select io_clk[1]
      cfg_clk_sel = 1'b1;
      pad_i = 1'b1;
      @(posedge clk1);
      #1 chk("R5 captured on selected clock", core_din, 1);
      @(negedge clk1);
      #1 pad_i = 1'b0;
      #9 chk("R5 unselected clock edges ignored", core_din, 1);
      @(posedge clk1);
      #1 chk("R5 R3 new value on selected clock", core_din, 0);

      // R4: latched input on io_clk[0]
      @(posedge clk0);
      #1 cfg_clk_sel = 1'b0; cfg_mode = 3'b010; pad_i = 1'b1;
      #1 chk("R4 transparent while clock high", core_din, 1);
      @(negedge clk0);
      #1 pad_i = 1'b0;
      #1 chk("R4 holds while clock low", core_din, 1);
      @(posedge clk0);
      #1 chk("R4 reopens on clock high", core_din, 0);

      // R6: asynchronous clear
      cfg_mode = 3'b001;
      pad_i = 1'b1;
      @(posedge clk0);
      #1 chk("R3 captured before reset", core_din, 1);
      rst_n = 1'b0;
      #1 chk("R6 async clear of flip-flop", core_din, 0);
      cfg_mode = 3'b010;
      #0.5 chk("R6 latch held clear with clock high", core_din, 0);
      @(negedge clk0);
      #1 rst_n = 1'b1;
      #1 chk("R6 latch still clear after release", core_din, 0);
      @(posedge clk0);
      #1 chk("R4 latch follows after reset", core_din, 1);

      done = 1'b1;
      finish_run();
   end
endmodule